// File: doc/BRIEF.md
# Double-Buffered Gamma and Common-Voltage Code Bank

This block holds the digital codes for sixteen output channels of a display reference generator. Fourteen channels set gamma reference levels and two set the common-voltage level. Every code is 10 bits wide. The serial front end delivers writes as a channel index and a code. Each channel has two registers. The preload register takes the write. The output register drives the converter for that channel.

A mode input selects when output registers change. With the mode input low (immediate mode), a write reaches the channel's output at the same clock edge as its preload register. With the mode input high (latched mode), writes only fill preload registers. A single update strobe then copies every preload register to its output in the same clock cycle. A whole new gamma curve can therefore be staged, and all channels change together.

A synchronous active-low reset clears both register stages of every channel. A clear request pulse, raised by the bus front end on a general-call reset, does the same.

Top module: `gamma_code_bank`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, all preload and output registers become zero at that edge. A later update strobe with no intervening write therefore still gives zero on every lane.
- R2: When `clr_req` is high at a rising edge, all preload and output registers become zero at that edge. The clear takes priority over a write or strobe in the same cycle.
- R3: In immediate mode (`hold_mode` = 0), a write with `wr_en` = 1 to index k sets channel k's output to `wr_code` at that same clock edge. All other channels' outputs are unchanged.
- R4: In latched mode (`hold_mode` = 1), a write without a strobe changes no output. It only stores the code in channel k's preload register.
- R5: When `upd_strobe` is high at a rising edge, every channel's output takes its preload value at that one edge. This holds in either mode.
- R6: When a write to channel k and an update strobe occur in the same cycle, channel k's output takes the newly written code.
- R7: A write whose index is 16 or more (`wr_idx` is 5 bits, values 16 to 31) changes neither preload nor output registers of any channel.
- R8: Channel indices 0 to 13 drive `gamma_codes` lane k at bits [k*10 +: 10]. Indices 14 and 15 drive `vcom_codes` lanes 0 and 1 at bits [(k-14)*10 +: 10].
- R9: Changing `hold_mode` from 1 to 0 does not, by itself, move pending preload data to the outputs.
- R10: Codes pass at full 10-bit resolution: 0x000 and 0x3FF are held and output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_req | input | 1 | One-cycle synchronous clear of all channel registers |
| hold_mode | input | 1 | 0 = immediate mode, 1 = latched mode |
| wr_en | input | 1 | Write strobe for one channel |
| wr_idx | input | 5 | Channel index of the write; 16 to 31 are ignored |
| wr_code | input | 10 | Code to write |
| upd_strobe | input | 1 | Copies all preload registers to outputs |
| gamma_codes | output | 140 | Fourteen gamma output codes, lane k at [k*10 +: 10] |
| vcom_codes | output | 20 | Two common-voltage output codes, lane j at [j*10 +: 10] |

## Verification
The main function is driven with these patterns:
- Writes in immediate mode, which show that outputs follow writes and that neighbouring channels stay untouched.
- Writes in latched mode with no strobe, which separate the preload stage from the output stage.
- Strobes with no write, which show the all-channel copy.
- Strobes coinciding with a write, which decide which source wins on that channel.

Loading all sixteen channels with distinct codes before one strobe shows that every lane is copied in one cycle and lands in the right bit position. Writes to out-of-range indices, followed by a strobe, show whether any hidden preload register was disturbed. A mode change from latched to immediate with data pending separates a level-sensitive copy from a strobe-driven one.

// File: rtl/gcb_pkg.sv
// Package: shared sizing constants and the channel code type for the
// gamma code bank. Assumes 10-bit codes and a 14 + 2 channel split.
package gcb_pkg;
    localparam int CODE_W_DEF  = 10;
    localparam int N_GAMMA_DEF = 14;
    localparam int N_VCOM_DEF  = 2;
    localparam int IDX_W_DEF   = 5;

    typedef logic [CODE_W_DEF-1:0] code_t;
endpackage

// File: rtl/gcb_wr_decode.sv
// Module: gcb_wr_decode
// Turns a write strobe and a channel index into a one-hot channel select.
// Assumes IDX_W is wide enough to name every channel. Indices at or above
// N_CH select nothing, so such writes are dropped.
module gcb_wr_decode #(
    parameter int N_CH  = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [N_CH-1:0]  wr_sel
);
    // One comparator per channel against its own constant index.
    for (genvar k = 0; k < N_CH; k++) begin : g_sel
        always_comb wr_sel[k] = wr_en && (wr_idx == IDX_W'(k));
    end

    // An out-of-range index must not reach any channel (R7).
    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) >= N_CH)) |-> (wr_sel == '0));

    // At most one channel is selected per write (R3).
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/gcb_channel.sv
// Module: gcb_channel
// One channel: a preload register fed by writes, and an output register.
// The output register is loaded either straight from the write (immediate
// mode, or write colliding with a strobe) or from the preload register on
// an update strobe. Assumes clear and reset are synchronous.
module gcb_channel #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hold_mode,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              upd,
    output logic [CODE_W-1:0] out_q
);
    logic [CODE_W-1:0] pre_q;
    logic              direct_load;

    // A write goes straight to the output in immediate mode or with a strobe.
    always_comb direct_load = wr_hit && (!hold_mode || upd);

    // Preload stage: capture every write aimed at this channel.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pre_q <= '0;
        else if (wr_hit)
            pre_q <= wr_code;
    end

    // Output stage: direct write wins over the strobe copy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            out_q <= '0;
        else if (direct_load)
            out_q <= wr_code;
        else if (upd)
            out_q <= pre_q;
    end

    // Checker arm flag: high once one edge after reset has passed.
    logic chk_live;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(clr)) |-> (out_q == '0 && pre_q == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && !$past(clr) && !$past(upd) &&
         !($past(wr_hit) && !$past(hold_mode))) |-> $stable(out_q));

    p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(upd) && !$past(wr_hit) && !$past(clr))
        |-> (out_q == $past(pre_q)));

    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(wr_hit) && !$past(clr) &&
         ($past(upd) || !$past(hold_mode))) |-> (out_q == $past(wr_code)));
endmodule

// File: rtl/gamma_code_bank.sv
// Module: gamma_code_bank
// Top of the double-buffered channel code bank. A decoder selects one
// channel per write. Each channel keeps a preload and an output register.
// Output lanes are split into gamma and common-voltage buses. Assumes the
// serial front end presents one write per cycle at most.
module gamma_code_bank #(
    parameter int CODE_W  = gcb_pkg::CODE_W_DEF,
    parameter int N_GAMMA = gcb_pkg::N_GAMMA_DEF,
    parameter int N_VCOM  = gcb_pkg::N_VCOM_DEF,
    parameter int IDX_W   = gcb_pkg::IDX_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_req,
    input  logic                      hold_mode,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [CODE_W-1:0]         wr_code,
    input  logic                      upd_strobe,
    output logic [N_GAMMA*CODE_W-1:0] gamma_codes,
    output logic [N_VCOM*CODE_W-1:0]  vcom_codes
);
    localparam int N_CH = N_GAMMA + N_VCOM;

    logic [N_CH-1:0]   wr_sel;
    logic [CODE_W-1:0] ch_out [N_CH];

    gcb_wr_decode #(.N_CH(N_CH), .IDX_W(IDX_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_sel (wr_sel)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        gcb_channel #(.CODE_W(CODE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_req),
            .hold_mode (hold_mode),
            .wr_hit    (wr_sel[k]),
            .wr_code   (wr_code),
            .upd       (upd_strobe),
            .out_q     (ch_out[k])
        );
    end

    // Lane mapping for the gamma bus: channel g drives lane g.
    for (genvar g = 0; g < N_GAMMA; g++) begin : g_gam
        always_comb gamma_codes[g*CODE_W +: CODE_W] = ch_out[g];
    end

    // Lane mapping for the common-voltage bus: channels after the gamma set.
    for (genvar c = 0; c < N_VCOM; c++) begin : g_com
        always_comb vcom_codes[c*CODE_W +: CODE_W] = ch_out[N_GAMMA + c];
    end

    // All lanes read zero one edge after reset (R1).
    logic seen_rst;
    always_ff @(posedge clk) seen_rst <= !rst_n;
    p_reset_zero_r1: assert property (@(posedge clk)
        seen_rst |-> (gamma_codes == '0 && vcom_codes == '0));
endmodule

// File: tb/sim_gamma_code_bank.sv
module sim_gamma_code_bank;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 10;
    localparam int NG = 14;
    localparam int NV = 2;
    localparam int NC = NG + NV;

    logic           clk = 1'b0;
    logic           rst_n, clr_req, hold_mode, wr_en, upd_strobe;
    logic [4:0]     wr_idx;
    logic [W-1:0]   wr_code;
    logic [NG*W-1:0] gamma_codes;
    logic [NV*W-1:0] vcom_codes;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_code_bank u0 (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .hold_mode(hold_mode),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
        .upd_strobe(upd_strobe), .gamma_codes(gamma_codes),
        .vcom_codes(vcom_codes)
    );

    // Read channel k through the lane mapping of R8.
    function automatic logic [W-1:0] ch(input int k);
        if (k < NG) return gamma_codes[k*W +: W];
        return vcom_codes[(k-NG)*W +: W];
    endfunction

    task automatic check(input string req, input int k, input logic [W-1:0] exp);
        checks++;
        if (ch(k) !== exp) begin
            errors++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, k, ch(k), exp);
        end
    endtask

    // Drive one cycle of inputs on the falling edge; results settle by the next one.
    task automatic step(input logic h, input logic w, input logic [4:0] i,
                        input logic [W-1:0] c, input logic u, input logic cl);
        hold_mode = h; wr_en = w; wr_idx = i; wr_code = c; upd_strobe = u; clr_req = cl;
        @(negedge clk);
        wr_en = 1'b0; upd_strobe = 1'b0; clr_req = 1'b0;
    endtask

    // Vector fields: hold, wr, idx[5], code[10], upd, chk[4], exp[10]
    localparam int NV_T = 14;
    localparam logic [31:0] VEC [NV_T] = '{
        {1'b0, 1'b1, 5'd3,  10'h155, 1'b0, 4'd3,  10'h155},  // R3
        {1'b0, 1'b1, 5'd15, 10'h3FF, 1'b0, 4'd15, 10'h3FF},  // R3 R8 R10
        {1'b1, 1'b1, 5'd3,  10'h0AA, 1'b0, 4'd3,  10'h155},  // R4
        {1'b1, 1'b1, 5'd0,  10'h001, 1'b0, 4'd0,  10'h000},  // R4
        {1'b1, 1'b0, 5'd0,  10'h000, 1'b1, 4'd3,  10'h0AA},  // R5
        {1'b1, 1'b0, 5'd0,  10'h000, 1'b0, 4'd0,  10'h001},  // R5
        {1'b1, 1'b1, 5'd7,  10'h200, 1'b1, 4'd7,  10'h200},  // R6
        {1'b1, 1'b1, 5'd20, 10'h111, 1'b1, 4'd4,  10'h000},  // R7
        {1'b1, 1'b1, 5'd5,  10'h123, 1'b0, 4'd5,  10'h000},  // R4
        {1'b0, 1'b0, 5'd0,  10'h000, 1'b0, 4'd5,  10'h000},  // R9
        {1'b0, 1'b0, 5'd0,  10'h000, 1'b1, 4'd5,  10'h123},  // R5
        {1'b0, 1'b1, 5'd14, 10'h3C3, 1'b0, 4'd14, 10'h3C3},  // R8
        {1'b1, 1'b1, 5'd14, 10'h000, 1'b1, 4'd14, 10'h000},  // R6 R10
        {1'b0, 1'b1, 5'd1,  10'h0F0, 1'b0, 4'd2,  10'h000}   // R3 neighbour
    };

    initial begin
        rst_n = 1'b0; clr_req = 1'b0; hold_mode = 1'b0; wr_en = 1'b0;
        upd_strobe = 1'b0; wr_idx = '0; wr_code = '0;
        @(negedge clk); @(negedge clk);
        for (int k = 0; k < NC; k++) check("R1", k, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV_T; v++) begin
            step(VEC[v][31], VEC[v][30], VEC[v][29:25], VEC[v][24:15], VEC[v][14], 1'b0);
            check($sformatf("R3-R10 vec%0d", v), int'(VEC[v][13:10]), VEC[v][9:0]);
        end

        // R2: clear wins over a simultaneous write and strobe.
        step(1'b1, 1'b1, 5'd15, 10'h2AB, 1'b1, 1'b1);
        for (int k = 0; k < NC; k++) check("R2", k, '0);

        // R4/R5: stage all channels in latched mode, then one strobe.
        for (int k = 0; k < NC; k++) step(1'b1, 1'b1, 5'(k), 10'(k*37 + 5), 1'b0, 1'b0);
        for (int k = 0; k < NC; k++) check("R4 staged", k, '0);
        step(1'b1, 1'b0, 5'd0, 10'h0, 1'b1, 1'b0);
        for (int k = 0; k < NC; k++) check("R5 copy", k, 10'(k*37 + 5));

        // R7: out-of-range writes, then a strobe, leave every channel intact.
        step(1'b0, 1'b1, 5'd16, 10'h3FF, 1'b0, 1'b0);
        step(1'b0, 1'b1, 5'd31, 10'h3FF, 1'b0, 1'b0);
        step(1'b1, 1'b0, 5'd0, 10'h0, 1'b1, 1'b0);
        for (int k = 0; k < NC; k++) check("R7", k, 10'(k*37 + 5));

        // R1: reset clears preload too; a strobe afterwards gives zeros.
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        step(1'b1, 1'b0, 5'd0, 10'h0, 1'b1, 1'b0);
        for (int k = 0; k < NC; k++) check("R1 preload", k, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule